// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This controller runs a serial EEPROM that has a chip select, a shift clock, a data line into the part and a data line back from it. A host pulses `start` with an operation code, an address and, for writes, a data word. The controller sends the command and then returns a one-cycle `done` pulse, with read data or a timeout flag where the operation produces one. Each command begins with a start bit that is always 1, followed by a two-bit opcode and then the address, most significant bit first. The shift clock is derived from the system clock, with a half-period set at run time.

The controller handles both common part sizes. A probe operation reads location all-ones using eight address bits. It then looks at the sample taken on the ninth shift clock. A part with six address bits has already driven its dummy zero by that clock. A part with eight address bits is still taking in its address, so the line is still pulled high. The width found this way is kept and is used for every later word access. A write operation is a complete unit: it enables programming, sends the word, polls the part until it reports ready, and disables programming again, all before it signals completion.

Top module: `uwire_eeprom_ctl`

## Requirements
- R1: Every command shifts a 1 start bit, then a 2-bit opcode (read 10, write 01, control 00), then the address MSB first at the detected width (8 bits when `addr8`=1, otherwise 6). A read or write word access uses 3+width+16 shift clocks, and the 16 write data bits follow the address MSB first.
- R2: `ee_di` changes only while `ee_sk` is low. `ee_do` is sampled at the end of the high half of each shift clock.
- R3: Each half of the shift clock lasts max(`div`, MIN_HALF) system clock cycles.
- R4: Operation codes 4 to 7 probe the address width. The probe is a read of location 0xFF with 8 address bits over 27 shift clocks. `addr8` becomes 1 if the sample on the 9th shift clock is 1, and becomes 0 otherwise.
- R5: `addr8` is 0 after reset. It changes only at the end of a probe.
- R6: Operation 0 (read) returns on `rdata` the 16 bits that follow the dummy zero. They are valid when `done` pulses and stay stable while the controller is idle.
- R7: Operation 1 (write) performs four steps in order: an enable command (opcode 00, top two address bits 11), the write command, a busy poll, and a disable command (opcode 00, top two address bits 00). It then pulses `done` once.
- R8: The busy poll holds chip select high with no shift clocks and samples `ee_do` once per half-period until it reads 1. After POLL_MAX samples it gives up, sets `timeout` and still sends the disable command.
- R9: Chip select is low for at least one half-period between commands. The shift clock is high only while chip select is high.
- R10: `done` is a single-cycle pulse. `busy` is high from the cycle after `start` until the cycle of `done`.
- R11: Operation 2 sends the enable command alone and operation 3 sends the disable command alone. Each is 3+width shift clocks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 3 | 0 read, 1 write, 2 enable, 3 disable, 4-7 probe |
| addr | input | 8 | Word address (low 6 bits used for a 6-bit part) |
| wdata | input | WORD_W | Word to write |
| div | input | DIV_W | Requested shift-clock half-period in system cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | WORD_W | Last word read |
| timeout | output | 1 | Busy poll gave up during the last write |
| addr8 | output | 1 | Detected address width is 8 bits |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The assertions check several wire-level rules on every cycle: data changes only while the shift clock is low, the shift clock never rises without chip select, a chip-select drop lasts more than one cycle, `done` lasts a single cycle, and `addr8`, `rdata` and `timeout` stay stable while the controller is idle. Other behaviour can only be shown by the bench scenarios running against a behavioural EEPROM model of either width: the bit counts per command, the order of enable, write, poll and disable, the width decision, the data returned, the measured half-period, and the exact length of a poll that gives up.

// File: rtl/uwire_eeprom_ctl.sv
module uwire_eeprom_ctl #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 2,
  parameter int POLL_MAX = 10000,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [7:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [DIV_W-1:0]  div,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              timeout,
  output logic              addr8,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int FRAME_W = 3 + 8 + WORD_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);
  localparam int CAP_W   = FRAME_W - 8;

  typedef enum logic [2:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_GAP, ST_POLL, ST_DONE} st_t;
  typedef enum logic [2:0] {K_RD, K_WR, K_WEN, K_WDS, K_PRB} kind_t;

  st_t                st;
  kind_t              kind;
  logic               is_wr, polled, tick;
  logic [DIV_W-1:0]   tmr, half;
  logic [BIT_W-1:0]   nbit, len;
  logic [POLL_W-1:0]  npoll;
  logic [FRAME_W-1:0] tx;
  logic [CAP_W-2:0]   cap;
  logic [CAP_W-1:0]   cap_nx;
  logic [7:0]         a_q;
  logic [WORD_W-1:0]  d_q;

  function automatic logic [FRAME_W-1:0] mk_frame(input kind_t k, input logic w8,
                                                  input logic [7:0] a, input logic [WORD_W-1:0] d);
    logic [2:0] o;
    logic [7:0] f;
    logic [WORD_W-1:0] dd;
    o  = (k == K_WR) ? 3'b101 : (k == K_RD || k == K_PRB) ? 3'b110 : 3'b100;
    f  = (k == K_PRB) ? 8'hFF : (k == K_WEN) ? (w8 ? 8'hC0 : 8'h30) :
         (k == K_WDS) ? 8'h00 : a;
    dd = (k == K_WR) ? d : '0;
    if (w8 || k == K_PRB) return {o, f, dd};
    return {o, f[5:0], dd, 2'b00};
  endfunction

  function automatic logic [BIT_W-1:0] mk_len(input kind_t k, input logic w8);
    int n;
    n = 3 + ((w8 || k == K_PRB) ? 8 : 6);
    if (k != K_WEN && k != K_WDS) n = n + WORD_W;
    return BIT_W'(n);
  endfunction

  function automatic kind_t first_kind(input logic [2:0] o);
    if (o[2]) return K_PRB;
    case (o[1:0])
      2'd0:    return K_RD;
      2'd3:    return K_WDS;
      default: return K_WEN;
    endcase
  endfunction

  assign half   = (div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : div;
  assign tick   = (tmr == half - 1'b1);
  assign cap_nx = {cap, ee_do};

  assign busy  = (st != ST_IDLE);
  assign done  = (st == ST_DONE);
  assign ee_cs = (st == ST_LOW) || (st == ST_HIGH) || (st == ST_POLL);
  assign ee_sk = (st == ST_HIGH);
  assign ee_di = ((st == ST_LOW) || (st == ST_HIGH)) && tx[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= K_RD;
      is_wr   <= 1'b0;
      polled  <= 1'b0;
      tmr     <= '0;
      nbit    <= '0;
      len     <= '0;
      npoll   <= '0;
      tx      <= '0;
      cap     <= '0;
      a_q     <= '0;
      d_q     <= '0;
      rdata   <= '0;
      timeout <= 1'b0;
      addr8   <= 1'b0;
    end else begin
      if (st == ST_IDLE) tmr <= '0;
      else tmr <= tick ? '0 : tmr + 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          a_q     <= addr;
          d_q     <= wdata;
          is_wr   <= (op == 3'd1);
          polled  <= 1'b0;
          timeout <= 1'b0;
          kind    <= first_kind(op);
          tx      <= mk_frame(first_kind(op), addr8, addr, wdata);
          len     <= mk_len(first_kind(op), addr8);
          nbit    <= '0;
          st      <= ST_LOW;
        end
        ST_LOW: if (tick) st <= ST_HIGH;
        ST_HIGH: if (tick) begin
          cap  <= cap_nx[CAP_W-2:0];
          tx   <= tx << 1;
          nbit <= nbit + 1'b1;
          if (nbit == len - 1'b1) begin
            st <= ST_GAP;
            if (kind == K_RD)  rdata <= cap_nx[WORD_W-1:0];
            if (kind == K_PRB) addr8 <= cap_nx[CAP_W-1];
          end else begin
            st <= ST_LOW;
          end
        end
        ST_GAP: if (tick) begin
          if (kind == K_WEN && is_wr) begin
            kind <= K_WR;
            tx   <= mk_frame(K_WR, addr8, a_q, d_q);
            len  <= mk_len(K_WR, addr8);
            nbit <= '0;
            st   <= ST_LOW;
          end else if (kind == K_WR && !polled) begin
            npoll <= '0;
            st    <= ST_POLL;
          end else if (kind == K_WR) begin
            kind <= K_WDS;
            tx   <= mk_frame(K_WDS, addr8, a_q, d_q);
            len  <= mk_len(K_WDS, addr8);
            nbit <= '0;
            st   <= ST_LOW;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_POLL: if (tick) begin
          if (ee_do) begin
            polled <= 1'b1;
            st     <= ST_GAP;
          end else if (npoll == POLL_W'(POLL_MAX - 1)) begin
            timeout <= 1'b1;
            polled  <= 1'b1;
            st      <= ST_GAP;
          end else begin
            npoll <= npoll + 1'b1;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uwire_eeprom_ctl_chk.sv
module uwire_eeprom_ctl_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] rdata,
  input logic              timeout,
  input logic              addr8,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di
);

  a_r2_di_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ee_di) |-> !ee_sk);

  a_r9_sk_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |=> !ee_cs);

  a_r3_sk_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |=> ee_sk);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r5_width_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(addr8));

  a_r6_rdata_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(rdata));

  a_r8_timeout_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(timeout));

endmodule

bind uwire_eeprom_ctl uwire_eeprom_ctl_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/uwire_eeprom_ctl_bench.sv
module uwire_eeprom_ctl_bench;
  localparam int MIN_HALF = 2;
  localparam int POLL_MAX = 10000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] addr = '0, div = '0;
  logic [15:0] wdata = '0;
  logic busy, done, timeout, addr8, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rdata;

  always #10 clk = ~clk;

  uwire_eeprom_ctl #(.DIV_W(8), .MIN_HALF(MIN_HALF), .POLL_MAX(POLL_MAX), .WORD_W(16)) u_uwire_eeprom_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata), .div(div),
    .busy(busy), .done(done), .rdata(rdata), .timeout(timeout), .addr8(addr8),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  // Behavioural EEPROM and wire monitor, evaluated on the falling clock edge
  logic [15:0] mem [256];
  bit m_aw8 = 1, m_wen = 0, m_wpend = 0, m_stuck = 0;
  int m_bitn = 0, m_addr = 0, m_busy = 0, busy_len = 100, m_badstart = 0;
  logic [31:0] m_sh = '0;
  logic [1:0] m_op = '0;
  logic [15:0] m_wdata = '0, m_rword = '0;
  logic rd_do = 1'b1, p_sk = 1'b0, p_cs = 1'b0, p_di = 1'b0;
  int fl[8], fc[8];
  int nf = 0, cur_r = 0, cur_c = 0, sk_run = 0, last_high = 0, gap_run = 0, min_gap = 0, di_bad = 0;

  assign ee_do = !ee_cs ? 1'b1 : (m_bitn == 0 ? (m_busy == 0 && !m_stuck) : rd_do);

  always @(negedge clk) begin
    int aw;
    aw = m_aw8 ? 8 : 6;
    if (m_busy > 0) m_busy--;
    if (ee_cs && !p_cs) begin
      m_bitn = 0; rd_do = 1'b1; cur_r = 0; cur_c = 0;
      if (busy && gap_run < min_gap) min_gap = gap_run;
    end
    if (!ee_cs && p_cs) begin
      if (m_wpend && m_wen) begin mem[m_addr] = m_wdata; m_busy = busy_len; end
      m_wpend = 0;
      if (nf < 8) begin fl[nf] = cur_r; fc[nf] = cur_c; end
      nf++;
    end
    if (ee_cs) cur_c++;
    gap_run = ee_cs ? 0 : gap_run + 1;
    if (ee_sk) sk_run++;
    else if (sk_run > 0) begin last_high = sk_run; sk_run = 0; end
    if (ee_sk && ee_di != p_di) di_bad++;
    if (ee_cs && ee_sk && !p_sk) begin
      cur_r++;
      m_bitn++;
      m_sh = {m_sh[30:0], ee_di};
      if (m_bitn == 1 && !ee_di) m_badstart++;
      if (m_bitn == 3) m_op = m_sh[1:0];
      if (m_bitn == 3 + aw) begin
        m_addr = int'(m_sh) & ((1 << aw) - 1);
        if (m_op == 2'b10) begin rd_do = 1'b0; m_rword = mem[m_addr]; end
        if (m_op == 2'b00) begin
          if (((m_addr >> (aw - 2)) & 3) == 3) m_wen = 1;
          if (((m_addr >> (aw - 2)) & 3) == 0) m_wen = 0;
        end
      end else if (m_bitn > 3 + aw && m_bitn <= 3 + aw + 16) begin
        if (m_op == 2'b10) rd_do = m_rword[15 - (m_bitn - 4 - aw)];
        if (m_op == 2'b01 && m_bitn == 3 + aw + 16) begin m_wpend = 1; m_wdata = m_sh[15:0]; end
      end else if (m_bitn > 3 + aw + 16) begin
        rd_do = 1'b1;
      end
    end
    p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di;
  end

  int total = 0, fails = 0;
  bit finished = 0;
  logic [15:0] got_rd;
  logic got_to, done_after, busy_after;

  function automatic int exp_half(input int dv);
    return (dv < MIN_HALF) ? MIN_HALF : dv;
  endfunction

  function automatic int exp_word_len(input bit w8);
    return 3 + (w8 ? 8 : 6) + 16;
  endfunction

  function automatic int exp_ctl_len(input bit w8);
    return 3 + (w8 ? 8 : 6);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [7:0] a, input logic [15:0] d, input logic [7:0] dv);
    int n;
    @(posedge clk); #1;
    op = o; addr = a; wdata = d; div = dv; start = 1'b1;
    nf = 0; min_gap = 1000000; di_bad = 0;
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    while (!done && n < 150000) begin @(posedge clk); #1; n++; end
    got_rd = rdata; got_to = timeout;
    @(posedge clk); #1;
    done_after = done; busy_after = busy;
    chk("R10", "done one cycle", {done_after, busy_after}, 2'b00);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog run did not finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5A3C;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R5", "addr8 after reset", addr8, 0);
    chk("R10", "busy after reset", busy, 0);
    chk("R9", "cs/sk after reset", {ee_cs, ee_sk}, 2'b00);

    m_aw8 = 1;
    do_op(3'd4, 8'h00, 16'h0, 8'd0);
    chk("R4", "probe 8-bit part", addr8, 1);
    chk("R4", "probe clocks", fl[0], 27);
    chk("R3", "half period div 0", last_high, exp_half(0));

    do_op(3'd0, 8'hA5, 16'h0, 8'd5);
    chk("R6", "read 8-bit", got_rd, mem[8'hA5]);
    chk("R1", "read clocks 8-bit", fl[0], exp_word_len(1));
    chk("R3", "half period div 5", last_high, exp_half(5));
    chk("R5", "addr8 held", addr8, 1);

    busy_len = 300;
    do_op(3'd1, 8'h3C, 16'hBEEF, 8'd3);
    chk("R7", "commands in write", nf, 4);
    chk("R7", "enable clocks", fl[0], exp_ctl_len(1));
    chk("R1", "write clocks", fl[1], exp_word_len(1));
    chk("R8", "poll has no clocks", fl[2], 0);
    chk("R7", "disable clocks", fl[3], exp_ctl_len(1));
    chk("R7", "left disabled", m_wen, 0);
    chk("R8", "no timeout", got_to, 0);
    chk("R9", "cs gap", min_gap >= exp_half(3), 1);
    chk("R2", "di while sk high", di_bad, 0);
    do_op(3'd0, 8'h3C, 16'h0, 8'd2);
    chk("R7", "readback", got_rd, 16'hBEEF);

    do_op(3'd2, 8'h00, 16'h0, 8'd1);
    chk("R11", "enable alone", m_wen, 1);
    chk("R11", "enable clocks", fl[0], exp_ctl_len(1));
    do_op(3'd3, 8'h00, 16'h0, 8'd1);
    chk("R11", "disable alone", m_wen, 0);

    m_aw8 = 0;
    do_op(3'd7, 8'h00, 16'h0, 8'd2);
    chk("R4", "probe 6-bit part", addr8, 0);
    do_op(3'd0, 8'h2A, 16'h0, 8'd2);
    chk("R6", "read 6-bit", got_rd, mem[8'h2A]);
    chk("R1", "read clocks 6-bit", fl[0], exp_word_len(0));

    for (int it = 0; it < 10; it++) begin
      bit w8;
      logic [7:0] a, dv;
      logic [15:0] d;
      w8 = bit'($urandom_range(0, 1));
      if (w8 != m_aw8) begin
        m_aw8 = w8;
        do_op(3'd4, 8'h00, 16'h0, 8'd0);
        chk("R4", "random probe", addr8, w8);
      end
      a = 8'($urandom_range(0, 255));
      if (!w8) a = a & 8'h3F;
      d = 16'($urandom_range(0, 65535));
      dv = 8'($urandom_range(0, 4));
      busy_len = $urandom_range(20, 400);
      do_op(3'd1, a, d, dv);
      chk("R7", "random write commands", nf, 4);
      chk("R1", "random write clocks", fl[1], exp_word_len(w8));
      chk("R9", "random cs gap", min_gap >= exp_half(dv), 1);
      chk("R2", "random di", di_bad, 0);
      do_op(3'd0, a, 16'h0, dv);
      chk("R6", "random readback", got_rd, d);
    end

    m_stuck = 1;
    do_op(3'd1, 8'h11, 16'h1234, 8'd0);
    chk("R8", "timeout flag", got_to, 1);
    chk("R8", "poll length", fc[2], POLL_MAX * exp_half(0));
    chk("R8", "disable after timeout", nf, 4);
    chk("R8", "left disabled", m_wen, 0);
    m_stuck = 0;
    m_busy = 0;

    m_aw8 = 1;
    do_op(3'd4, 8'h00, 16'h0, 8'd0);
    chk("R5", "addr8 before reset", addr8, 1);
    #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R5", "addr8 cleared by reset", addr8, 0);
    chk("R1", "start bits", m_badstart, 0);
    summary();
  end
endmodule